// File: doc/BRIEF.md
# JTAG Scan Vector Sequencer

This block runs one JTAG test access port through a programmed number of TCK pulses. A start request latches every run parameter: the pulse count, a 12-bit TMS pattern, the TCK rate code and three option flags. Because of the latch, the host may rewrite any of these inputs while the scan is running. TDI data comes least significant bit first from a 1-bit-wide output buffer. TDO can be captured into a 1-bit-wide input buffer at the same addresses. Both buffers hold 4096 bits and use synchronous access.

TCK is made from a clock-enable tick. The tick's half period is `(rate+1)*DIV_UNIT` system cycles, so code 0 is the fastest rate and each larger code is slower. TDI and TMS change when TCK falls. TDO is sampled when TCK rises. For pulse k, TMS takes bit k of the pattern. Pulses past the end of the pattern reuse the pattern's top bit. An option can force TMS high on the final pulse. The host loads the output buffer and reads back the input buffer through simple bit-wide ports.

Top module: `jtag_scan_seq`

## Requirements
- R1: After reset, busy_o, done_o, tck_o, tms_o and tdi_o are all 0.
- R2: A start accepted with bits_i = N produces exactly N TCK pulses. When N = 0 there are no pulses, busy_o stays 0 and done_o is 1 for the single cycle after the start edge.
- R3: On pulse k (counting from 0), tms_o equals tms_pat_i[k] for k < 12 and tms_pat_i[11] for k >= 12, using the pattern latched at start.
- R4: When tms_last_i was 1 at start, tms_o is 1 on pulse N-1 regardless of the pattern.
- R5: When drive_i was 1 at start, tdi_o on pulse k equals output-buffer bit k (address k). When it was 0, tdi_o stays 0.
- R6: When store_i was 1 at start, the input buffer at address k receives the tdo_i value present at rising edge k of TCK. When store_i was 0, the input buffer is not changed. The host reads the buffer with one cycle of latency.
- R7: With L = (rate+1)*DIV_UNIT and E0 the accepting clock edge, rising edge k of TCK occurs at E0 + L*(2k+2) and the final falling edge at E0 + L*(2N+1).
- R8: busy_o goes to 1 in the cycle after an accepted start with N > 0. It goes to 0 at the final falling edge of TCK, together with a one-cycle done_o pulse.
- R9: While busy_o is 1, start requests and changes on bits_i, tms_pat_i, rate_i and the flag inputs have no effect on the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| bits_i | input | 12 | Number of TCK pulses |
| tms_pat_i | input | 12 | TMS pattern, bit k for pulse k |
| store_i | input | 1 | Capture TDO into the input buffer |
| drive_i | input | 1 | Drive TDI from the output buffer |
| tms_last_i | input | 1 | Force TMS high on the final pulse |
| rate_i | input | 4 | TCK rate code, 0 is fastest |
| obuf_we_i | input | 1 | Host write strobe for the output buffer |
| obuf_waddr_i | input | 12 | Host write address |
| obuf_wdata_i | input | 1 | Host write data |
| ibuf_raddr_i | input | 12 | Host read address for the input buffer |
| ibuf_rdata_o | output | 1 | Registered input-buffer read data |
| tdo_i | input | 1 | Test data from the TAP |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the TAP |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 12-bit addresses, which give the full 4096-bit buffers, a 12-bit pattern, 4-bit rate codes and DIV_UNIT = 2. With these values, scans longer than the pattern show the top bit being reused. A 300-pulse scan exercises buffer addresses well beyond the pattern. The slowest rate code checks edge placement at a 32-cycle half period, and the fastest checks the two-cycle minimum, where the buffer prefetch has the least slack.

// File: rtl/jscan_pkg.sv
package jscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_LOW,
    ST_HIGH
  } scan_st_e;
endpackage

// File: rtl/jscan_tick.sv
module jscan_tick #(
  parameter int RATE_W   = 4,
  parameter int DIV_UNIT = 2   // must be >= 2 (buffer prefetch slack)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int LIM_W = RATE_W + $clog2(DIV_UNIT) + 1;

  logic [LIM_W-1:0] lim;
  logic [LIM_W-1:0] cnt;

  assign lim    = LIM_W'((32'(rate_i) + 32'd1) * DIV_UNIT);
  assign tick_o = !clr_i && (cnt == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (clr_i)  cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < lim);
  a_r7_tick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt == '0));
endmodule

// File: rtl/jscan_buf.sv
module jscan_buf #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/jscan_ctrl.sv
module jscan_ctrl
  import jscan_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAT_W  = 12,
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] bits_i,
  input  logic [PAT_W-1:0]  tms_pat_i,
  input  logic              store_i,
  input  logic              drive_i,
  input  logic              tms_last_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              tick_i,
  output logic              tick_clr_o,
  output logic [RATE_W-1:0] rate_q_o,
  output logic [ADDR_W-1:0] obuf_raddr_o,
  input  logic              obuf_rdata_i,
  output logic              ibuf_we_o,
  output logic [ADDR_W-1:0] ibuf_waddr_o,
  output logic              ibuf_wdata_o,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PI_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  scan_st_e          st;
  logic [ADDR_W-1:0] idx, bits_q, last_idx;
  logic [PAT_W-1:0]  pat_q;
  logic              store_q, drive_q, tms_last_q;

  assign last_idx = bits_q - 1'b1;

  function automatic logic tms_for(input logic [ADDR_W-1:0] k);
    logic b;
    if (k >= ADDR_W'(PAT_W - 1)) b = pat_q[PAT_W-1];
    else                         b = pat_q[k[PI_W-1:0]];
    if (tms_last_q && (k == last_idx)) b = 1'b1;
    return b;
  endfunction

  assign tick_clr_o   = (st == ST_IDLE);
  // during the high phase, prefetch the next bit
  assign obuf_raddr_o = (st == ST_HIGH) ? idx + 1'b1 : idx;
  assign ibuf_we_o    = (st == ST_LOW) && tick_i && store_q;
  assign ibuf_waddr_o = idx;
  assign ibuf_wdata_o = tdo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      idx        <= '0;
      bits_q     <= '0;
      pat_q      <= '0;
      store_q    <= 1'b0;
      drive_q    <= 1'b0;
      tms_last_q <= 1'b0;
      rate_q_o   <= '0;
      tck_o      <= 1'b0;
      tms_o      <= 1'b0;
      tdi_o      <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (bits_i == '0) begin
              done_o <= 1'b1;
            end else begin
              bits_q     <= bits_i;
              pat_q      <= tms_pat_i;
              store_q    <= store_i;
              drive_q    <= drive_i;
              tms_last_q <= tms_last_i;
              rate_q_o   <= rate_i;
              idx        <= '0;
              busy_o     <= 1'b1;
              st         <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (tick_i) begin
            tdi_o <= drive_q & obuf_rdata_i;
            tms_o <= tms_for(idx);
            st    <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            tck_o <= 1'b1;
            st    <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick_i) begin
            tck_o <= 1'b0;
            if (idx == last_idx) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
              tdi_o  <= 1'b0;
              st     <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              tdi_o <= drive_q & obuf_rdata_i;
              tms_o <= tms_for(idx + 1'b1);
              st    <= ST_LOW;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r8_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && start_i && bits_i != '0) |=> busy_o);
  a_r2_zero_bits_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && start_i && bits_i == '0) |=> (done_o && !busy_o));
  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r2_tck_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tck_o);
  a_r4_tms_forced_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tck_o) && tms_last_q && idx == last_idx) |-> tms_o);
  a_r5_tdi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !drive_q && st != ST_FIRST) |-> !tdi_o);
  a_r9_params_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(bits_q) && $stable(pat_q) && $stable(rate_q_o)));
endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq #(
  parameter int ADDR_W   = 12,
  parameter int PAT_W    = 12,
  parameter int RATE_W   = 4,
  parameter int DIV_UNIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] bits_i,
  input  logic [PAT_W-1:0]  tms_pat_i,
  input  logic              store_i,
  input  logic              drive_i,
  input  logic              tms_last_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              obuf_we_i,
  input  logic [ADDR_W-1:0] obuf_waddr_i,
  input  logic              obuf_wdata_i,
  input  logic [ADDR_W-1:0] ibuf_raddr_i,
  output logic              ibuf_rdata_o,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              tick, tick_clr;
  logic [RATE_W-1:0] rate_q;
  logic [ADDR_W-1:0] obuf_raddr, ibuf_waddr;
  logic              obuf_rdata, ibuf_we, ibuf_wdata;

  jscan_tick #(.RATE_W(RATE_W), .DIV_UNIT(DIV_UNIT)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .rate_i(rate_q),
    .tick_o(tick)
  );

  jscan_buf #(.ADDR_W(ADDR_W)) u_obuf (
    .clk_i  (clk_i),
    .we_i   (obuf_we_i),
    .waddr_i(obuf_waddr_i),
    .wdata_i(obuf_wdata_i),
    .raddr_i(obuf_raddr),
    .rdata_o(obuf_rdata)
  );

  jscan_buf #(.ADDR_W(ADDR_W)) u_ibuf (
    .clk_i  (clk_i),
    .we_i   (ibuf_we),
    .waddr_i(ibuf_waddr),
    .wdata_i(ibuf_wdata),
    .raddr_i(ibuf_raddr_i),
    .rdata_o(ibuf_rdata_o)
  );

  jscan_ctrl #(.ADDR_W(ADDR_W), .PAT_W(PAT_W), .RATE_W(RATE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bits_i      (bits_i),
    .tms_pat_i   (tms_pat_i),
    .store_i     (store_i),
    .drive_i     (drive_i),
    .tms_last_i  (tms_last_i),
    .rate_i      (rate_i),
    .tick_i      (tick),
    .tick_clr_o  (tick_clr),
    .rate_q_o    (rate_q),
    .obuf_raddr_o(obuf_raddr),
    .obuf_rdata_i(obuf_rdata),
    .ibuf_we_o   (ibuf_we),
    .ibuf_waddr_o(ibuf_waddr),
    .ibuf_wdata_o(ibuf_wdata),
    .tdo_i       (tdo_i),
    .tck_o       (tck_o),
    .tms_o       (tms_o),
    .tdi_o       (tdi_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );
endmodule

// File: tb/tb_jtag_scan_seq.sv
module tb_jtag_scan_seq;
  localparam int DEPTH = 4096;
  localparam int UNIT  = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, store_i = 1'b0, drive_i = 1'b0, tms_last_i = 1'b0;
  logic [11:0] bits_i = '0, tms_pat_i = '0;
  logic [3:0]  rate_i = '0;
  logic        obuf_we_i = 1'b0, obuf_wdata_i = 1'b0;
  logic [11:0] obuf_waddr_i = '0, ibuf_raddr_i = '0;
  logic        ibuf_rdata_o, tdo_i, tck_o, tms_o, tdi_o, busy_o, done_o;

  jtag_scan_seq dut (.*);

  always #10 clk_i = ~clk_i;

  int  checks = 0, errors = 0;
  bit  finished = 0;
  logic tdo_src [DEPTH];
  logic obuf_m  [DEPTH];
  logic ibuf_m  [DEPTH];
  bit   ibuf_k  [DEPTH];
  logic tdi_rec [DEPTH];
  logic tms_rec [DEPTH];

  int nck = 0, t0 = 0, t_end = 0, rise_cnt = 0, total_rises = 0, timing_bad = 0, cur_l = 2;
  bit prev_tck = 0, prev_busy = 0, done_at_end = 0;

  assign tdo_i = tdo_src[rise_cnt % DEPTH];

  always @(negedge clk_i) begin
    nck = nck + 1;
    if (busy_o && !prev_busy) begin
      t0 = nck; rise_cnt = 0; timing_bad = 0;
    end
    if (tck_o && !prev_tck) begin
      tdi_rec[rise_cnt % DEPTH] = tdi_o;
      tms_rec[rise_cnt % DEPTH] = tms_o;
      if (nck != t0 + cur_l * (2 * rise_cnt + 2)) timing_bad = timing_bad + 1;
      rise_cnt = rise_cnt + 1;
      total_rises = total_rises + 1;
    end
    if (!busy_o && prev_busy) begin
      t_end = nck; done_at_end = done_o;
    end
    prev_tck  = tck_o;
    prev_busy = busy_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_tms(input int k, input int b, input logic [11:0] p, input bit raise);
    if (raise && k == b - 1) return 1'b1;
    return (k >= 12) ? p[11] : p[k];
  endfunction

  task automatic run_scan(input int b, input logic [11:0] pat, input bit st, input bit dr,
                          input bit raise, input int rate, input bit poke);
    int tot, bad_tms, bad_last, bad_tdi, bad_rd, n;
    cur_l = (rate + 1) * UNIT;
    n = (b + 4 < DEPTH) ? b + 4 : DEPTH;
    for (int i = 0; i < n; i++) begin
      tdo_src[i] = 1'($urandom);
      obuf_m[i]  = 1'($urandom);
      @(negedge clk_i);
      obuf_we_i = 1'b1; obuf_waddr_i = 12'(i); obuf_wdata_i = obuf_m[i];
    end
    @(negedge clk_i);
    obuf_we_i = 1'b0;
    tot = total_rises;
    bits_i = 12'(b); tms_pat_i = pat; store_i = st; drive_i = dr;
    tms_last_i = raise; rate_i = 4'(rate); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == (b != 0), "R8 busy after start", busy_o, b != 0);
    chk(done_o == (b == 0), "R2 done after start", done_o, b == 0);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      bits_i = 12'd7; tms_pat_i = ~pat; store_i = ~st; drive_i = ~dr;
      tms_last_i = ~raise; rate_i = 4'(rate + 3); start_i = 1'b1;
      repeat (2) @(negedge clk_i);
      start_i = 1'b0;
    end
    for (int w = 0; w < 150000 && busy_o; w++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(total_rises - tot == b, "R2 pulse count", total_rises - tot, b);
    if (b > 0) begin
      chk(timing_bad == 0, poke ? "R9 rate held, R7 edges" : "R7 rise timing", timing_bad, 0);
      chk(t_end == t0 + cur_l * (2 * b + 1), "R7 final fall", t_end - t0, cur_l * (2 * b + 1));
      chk(done_at_end == 1'b1, "R8 done with busy fall", done_at_end, 1);
      bad_tms = 0; bad_last = 0; bad_tdi = 0;
      for (int k = 0; k < b; k++) begin
        if (tms_rec[k] !== exp_tms(k, b, pat, raise)) begin
          if (raise && k == b - 1) bad_last++; else bad_tms++;
        end
        if (tdi_rec[k] !== (dr ? obuf_m[k] : 1'b0)) bad_tdi++;
      end
      chk(bad_tms == 0, poke ? "R9 pattern held, R3 tms" : "R3 tms pattern", bad_tms, 0);
      if (raise) chk(bad_last == 0, "R4 tms forced last", bad_last, 0);
      chk(bad_tdi == 0, dr ? "R5 tdi from buffer" : "R5 tdi held zero", bad_tdi, 0);
      if (st) for (int k = 0; k < b; k++) begin ibuf_m[k] = tdo_src[k]; ibuf_k[k] = 1'b1; end
    end
    bad_rd = 0;
    for (int i = 0; i < n; i++) begin
      if (ibuf_k[i]) begin
        @(negedge clk_i);
        ibuf_raddr_i = 12'(i);
        @(negedge clk_i);
        if (ibuf_rdata_o !== ibuf_m[i]) bad_rd++;
      end
    end
    chk(bad_rd == 0, st ? "R6 tdo captured" : "R6 buffer unchanged", bad_rd, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin
      tdo_src[i] = 1'b0; obuf_m[i] = 1'b0; ibuf_m[i] = 1'b0; ibuf_k[i] = 1'b0;
      tdi_rec[i] = 1'b0; tms_rec[i] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !tck_o && !tms_o && !tdi_o, "R1 reset outputs",
        {busy_o, done_o, tck_o, tms_o, tdi_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_scan(0, 12'hfff, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run_scan(1, 12'h000, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run_scan(12, 12'ha5c, 1'b1, 1'b1, 1'b0, 1, 1'b0);
    run_scan(13, 12'h7ff, 1'b0, 1'b1, 1'b0, 2, 1'b0);
    run_scan(20, 12'h800, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    run_scan(40, 12'h3c9, 1'b1, 1'b1, 1'b0, 15, 1'b0);
    run_scan(300, 12'h5a5, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run_scan(25, 12'h0f0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    run_scan(30, 12'h1b3, 1'b1, 1'b1, 1'b0, 1, 1'b1);
    for (int r = 0; r < 12; r++) begin
      run_scan(1 + int'($urandom % 40), 12'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), int'($urandom % 4), 1'b0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule